// File: doc/BRIEF.md
# Timer Event Flag Register

This block holds the three pending-event flags of one 8-bit timer/counter: counter overflow, compare-match A and compare-match B. The timer logic delivers each event as a one-cycle pulse, and the matching flag sets on that pulse. Each flag stays set until software writes a one to its bit or until the CPU acknowledges that flag's interrupt vector. Each flag is gated with its own enable bit and a global interrupt enable to form one of three interrupt request lines.

The overflow event source depends on the counter mode. In normal counting the flag follows the wrap-around pulse. In PWM counting it follows the pulse the timer raises when the count reverses direction at zero.

The register answers two address views on the same bus. The data-space view sits at a parameterised offset (default 0x37). The I/O-space view sits 0x20 lower (default 0x17).

Top module: `tmr_evt_flags`

## Requirements
- R1: After synchronous reset, all flags are zero, `rd_data` is 0x00 and `irq_req` is 3'b000.
- R2: Read data carries the overflow flag in bit 0, the compare-A flag in bit 1 and the compare-B flag in bit 2. Bits 7 to 3 always read as zero.
- R3: A one-cycle pulse on `cmpa_evt` or `cmpb_evt`, or on the selected overflow source, sets the matching flag at the next clock edge. The flag then holds until it is cleared.
- R4: A register write clears each flag whose bit in `wr_data` is one. It leaves flags whose bit is zero unchanged. Bits 7 to 3 of `wr_data` have no effect.
- R5: `irq_ack[i]` high for one cycle clears flag i, where index 0 is overflow, 1 is compare-A and 2 is compare-B. Other flags are untouched.
- R6: When a set pulse and a clear (write-one or acknowledge) reach the same flag in the same cycle, the flag ends up set.
- R7: `irq_req[i]` is one exactly when `glob_en`, `int_en[i]` and flag i are all one. It follows the registered flags without further delay.
- R8: The register is selected when `bus_space`=0 and `bus_addr`=0x37, or when `bus_space`=1 and `bus_addr`=0x17. A write to any other address or view leaves the flags unchanged, and a read of any other address or view returns 0x00.
- R9: With `pwm_mode`=0 the overflow flag sets from `ovf_evt_wrap` and ignores `ovf_evt_bottom`. With `pwm_mode`=1 it sets from `ovf_evt_bottom` and ignores `ovf_evt_wrap`.
- R10: `rd_data` is registered. It appears in the cycle after `rd_en` and shows the flags as they stood before any clear applied in the read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_space | input | 1 | Address view: 0 data space, 1 I/O space |
| bus_addr | input | 8 | Bus address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data, a one clears the matching flag |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| pwm_mode | input | 1 | Selects the overflow event source |
| ovf_evt_wrap | input | 1 | Counter wrap-around pulse |
| ovf_evt_bottom | input | 1 | Direction reversal at zero pulse |
| cmpa_evt | input | 1 | Compare-A match pulse |
| cmpb_evt | input | 1 | Compare-B match pulse |
| irq_ack | input | 3 | Per-vector interrupt acknowledge strobes |
| int_en | input | 3 | Per-flag interrupt enables |
| glob_en | input | 1 | Global interrupt enable |
| irq_req | output | 3 | Interrupt request lines |

## Verification
The bench targets several corner cases, each paired with the fault it would expose:

- **Set and clear in one cycle.** A design that let the clear win would lose a match event.
- **Writing zeros and upper bits.** A design that cleared on any write, or decoded the unused upper bits, would lose pending flags.
- **Address views.** The data-space offset is driven on the I/O view and the I/O offset on the data view. A decoder that ignored the view bit would respond to the wrong address.
- **Overflow source in each mode.** Both pulses are driven in both modes, so a swapped or missing mode select shows up.
- **Read during a clear.** The bench reads and clears in the same cycle. A design that returned post-clear data would hide the event from software.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
  localparam int NFLAG    = 3;
  localparam int FLG_OVF  = 0;
  localparam int FLG_CMPA = 1;
  localparam int FLG_CMPB = 2;

  typedef enum logic {
    SPACE_DATA = 1'b0,
    SPACE_IO   = 1'b1
  } space_e;
endpackage

// File: rtl/tmr_evt_decode.sv
module tmr_evt_decode
  import tmr_evt_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] DATA_OFS = 'h37,
  parameter logic [ADDR_W-1:0] IO_OFS   = 'h17
) (
  input  logic              bus_space,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic              wr_hit,
  output logic              rd_hit
);
  space_e space;
  logic   sel;

  assign space = space_e'(bus_space);

  always_comb begin
    unique case (space)
      SPACE_DATA: sel = (bus_addr == DATA_OFS);
      SPACE_IO:   sel = (bus_addr == IO_OFS);
      default:    sel = 1'b0;
    endcase
  end

  assign wr_hit = wr_en & sel;
  assign rd_hit = rd_en & sel;
endmodule

// File: rtl/tmr_evt_flag.sv
module tmr_evt_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end

  // R3, R6: a set pulse always leaves the flag high
  p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q);

  // R4, R5: a clear without a set drops the flag
  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !q);

  // R3: with neither set nor clear the flag holds
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !set_i) |=> $stable(q));
endmodule

// File: rtl/tmr_evt_irq.sv
module tmr_evt_irq #(
  parameter int N = 3
) (
  input  logic [N-1:0] flags,
  input  logic [N-1:0] int_en,
  input  logic         glob_en,
  output logic [N-1:0] irq_req
);
  for (genvar i = 0; i < N; i++) begin : g_gate
    assign irq_req[i] = glob_en & int_en[i] & flags[i];
  end
endmodule

// File: rtl/tmr_evt_flags.sv
module tmr_evt_flags
  import tmr_evt_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] DATA_OFS = 'h37,
  parameter logic [ADDR_W-1:0] IO_SHIFT = 'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_space,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              pwm_mode,
  input  logic              ovf_evt_wrap,
  input  logic              ovf_evt_bottom,
  input  logic              cmpa_evt,
  input  logic              cmpb_evt,
  input  logic [NFLAG-1:0]  irq_ack,
  input  logic [NFLAG-1:0]  int_en,
  input  logic              glob_en,
  output logic [NFLAG-1:0]  irq_req
);
  localparam logic [ADDR_W-1:0] IO_OFS = DATA_OFS - IO_SHIFT;

  logic             wr_hit, rd_hit;
  logic [NFLAG-1:0] evt, clr, flags;
  logic             unused_wr_hi;

  assign unused_wr_hi = ^wr_data[DATA_W-1:NFLAG];

  tmr_evt_decode #(
    .ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .IO_OFS(IO_OFS)
  ) u_dec (
    .bus_space(bus_space), .bus_addr(bus_addr),
    .wr_en(wr_en), .rd_en(rd_en),
    .wr_hit(wr_hit), .rd_hit(rd_hit)
  );

  // overflow source follows counting mode
  assign evt[FLG_OVF]  = pwm_mode ? ovf_evt_bottom : ovf_evt_wrap;
  assign evt[FLG_CMPA] = cmpa_evt;
  assign evt[FLG_CMPB] = cmpb_evt;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    assign clr[i] = (wr_hit & wr_data[i]) | irq_ack[i];
    tmr_evt_flag u_flag (
      .clk(clk), .rst(rst), .set_i(evt[i]), .clr_i(clr[i]), .q(flags[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_hit) rd_data <= {{(DATA_W-NFLAG){1'b0}}, flags};
    else             rd_data <= '0;
  end

  tmr_evt_irq #(.N(NFLAG)) u_irq (
    .flags(flags), .int_en(int_en), .glob_en(glob_en), .irq_req(irq_req)
  );

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    rd_data[DATA_W-1:NFLAG] == '0);

  p_irq_needs_glob_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_req != '0) |-> glob_en);

  p_foreign_wr_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en && irq_ack == '0 && !cmpa_evt && !cmpb_evt
     && !ovf_evt_wrap && !ovf_evt_bottom
     && !((bus_space == 1'b0 && bus_addr == DATA_OFS) ||
          (bus_space == 1'b1 && bus_addr == IO_OFS)))
    |=> $stable(flags));

  p_pwm_ignores_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (pwm_mode && !ovf_evt_bottom && !flags[FLG_OVF]) |=> !flags[FLG_OVF]);

  p_read_preclear_r10: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> (rd_data[NFLAG-1:0] == $past(flags)));
endmodule

// File: tb/tmr_evt_flags_tb.sv
module tmr_evt_flags_tb;
  localparam logic [7:0] A_DATA = 8'h37;
  localparam logic [7:0] A_IO   = 8'h17;

  logic       clk = 1'b0, rst = 1'b1;
  logic       bus_space = 1'b0;
  logic [7:0] bus_addr = '0, wr_data = '0, rd_data;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic       pwm_mode = 1'b0, ovf_evt_wrap = 1'b0, ovf_evt_bottom = 1'b0;
  logic       cmpa_evt = 1'b0, cmpb_evt = 1'b0, glob_en = 1'b0;
  logic [2:0] irq_ack = '0, int_en = '0, irq_req;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr_evt_flags u_dut (
    .clk(clk), .rst(rst), .bus_space(bus_space), .bus_addr(bus_addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .pwm_mode(pwm_mode), .ovf_evt_wrap(ovf_evt_wrap),
    .ovf_evt_bottom(ovf_evt_bottom), .cmpa_evt(cmpa_evt), .cmpb_evt(cmpb_evt),
    .irq_ack(irq_ack), .int_en(int_en), .glob_en(glob_en), .irq_req(irq_req)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic bus_wr(input logic sp, input logic [7:0] a, input logic [7:0] d);
    bus_space = sp; bus_addr = a; wr_data = d; wr_en = 1'b1;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic bus_rd(input logic sp, input logic [7:0] a, output logic [7:0] v);
    bus_space = sp; bus_addr = a; rd_en = 1'b1;
    step();
    rd_en = 1'b0; v = rd_data;
  endtask

  task automatic pulse(input logic w, input logic b, input logic ca, input logic cb);
    ovf_evt_wrap = w; ovf_evt_bottom = b; cmpa_evt = ca; cmpb_evt = cb;
    step();
    ovf_evt_wrap = 0; ovf_evt_bottom = 0; cmpa_evt = 0; cmpb_evt = 0;
  endtask

  task automatic set_all();
    pwm_mode = 1'b0; pulse(1, 0, 1, 1);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 irq_req after reset", {5'b0, irq_req}, 8'h00);
    chk("R1 rd_data after reset", rd_data, 8'h00);
    bus_rd(0, A_DATA, v);
    chk("R1 flags after reset", v, 8'h00);
  endtask

  task automatic t_set();
    logic [7:0] v;
    pulse(0, 0, 1, 0); bus_rd(0, A_DATA, v);
    chk("R3 R2 compare-A in bit1", v, 8'h02);
    pulse(0, 0, 0, 1); bus_rd(0, A_DATA, v);
    chk("R3 R2 compare-B in bit2", v, 8'h06);
    pulse(1, 0, 0, 0); bus_rd(0, A_DATA, v);
    chk("R3 R2 overflow in bit0", v, 8'h07);
    step(); step(); bus_rd(0, A_DATA, v);
    chk("R3 flags hold", v, 8'h07);
    bus_wr(0, A_DATA, 8'hFF);
  endtask

  task automatic t_w1c();
    logic [7:0] v;
    set_all();
    bus_wr(0, A_DATA, 8'h02); bus_rd(0, A_DATA, v);
    chk("R4 write-one clears bit1 only", v, 8'h05);
    bus_wr(0, A_DATA, 8'h00); bus_rd(0, A_DATA, v);
    chk("R4 write zero no effect", v, 8'h05);
    bus_wr(0, A_DATA, 8'hF8); bus_rd(0, A_DATA, v);
    chk("R4 upper write bits no effect", v, 8'h05);
    bus_wr(0, A_DATA, 8'h05); bus_rd(0, A_DATA, v);
    chk("R4 clear remaining", v, 8'h00);
  endtask

  task automatic t_ack();
    logic [7:0] v;
    set_all();
    irq_ack = 3'b100; step(); irq_ack = '0;
    bus_rd(0, A_DATA, v);
    chk("R5 ack clears compare-B", v, 8'h03);
    irq_ack = 3'b001; step(); irq_ack = '0;
    bus_rd(0, A_DATA, v);
    chk("R5 ack clears overflow", v, 8'h02);
    irq_ack = 3'b010; step(); irq_ack = '0;
  endtask

  task automatic t_collision();
    logic [7:0] v;
    cmpa_evt = 1'b1; bus_wr(0, A_DATA, 8'h02); cmpa_evt = 1'b0;
    bus_rd(0, A_DATA, v);
    chk("R6 set beats write-one", v, 8'h02);
    cmpb_evt = 1'b1; irq_ack = 3'b100; step(); cmpb_evt = 1'b0; irq_ack = '0;
    bus_rd(0, A_DATA, v);
    chk("R6 set beats acknowledge", v, 8'h06);
    bus_wr(0, A_DATA, 8'h07);
  endtask

  task automatic t_mask();
    set_all();
    glob_en = 1'b1; int_en = 3'b000; #1;
    chk("R7 no enables", {5'b0, irq_req}, 8'h00);
    int_en = 3'b001; #1;
    chk("R7 overflow enable only", {5'b0, irq_req}, 8'h01);
    int_en = 3'b010; #1;
    chk("R7 compare-A enable only", {5'b0, irq_req}, 8'h02);
    int_en = 3'b111; #1;
    chk("R7 all enabled", {5'b0, irq_req}, 8'h07);
    glob_en = 1'b0; #1;
    chk("R7 global enable off", {5'b0, irq_req}, 8'h00);
    glob_en = 1'b1; irq_ack = 3'b010; step(); irq_ack = '0; #1;
    chk("R7 request follows cleared flag", {5'b0, irq_req}, 8'h05);
    glob_en = 1'b0; int_en = '0;
    bus_wr(0, A_DATA, 8'h07);
  endtask

  task automatic t_views();
    logic [7:0] v;
    set_all();
    bus_wr(0, A_IO, 8'h07);   bus_rd(1, A_IO, v);
    chk("R8 data view at I/O offset ignored", v, 8'h07);
    bus_wr(1, A_DATA, 8'h07); bus_rd(1, A_IO, v);
    chk("R8 I/O view at data offset ignored", v, 8'h07);
    bus_rd(0, A_IO, v);
    chk("R8 read of other address", v, 8'h00);
    bus_rd(0, 8'h38, v);
    chk("R8 read of neighbour address", v, 8'h00);
    bus_wr(1, A_IO, 8'h01);   bus_rd(0, A_DATA, v);
    chk("R8 I/O view write clears", v, 8'h06);
    bus_wr(0, A_DATA, 8'h06);
  endtask

  task automatic t_pwm();
    logic [7:0] v;
    pwm_mode = 1'b1;
    pulse(1, 0, 0, 0); bus_rd(0, A_DATA, v);
    chk("R9 pwm ignores wrap", v, 8'h00);
    pulse(0, 1, 0, 0); bus_rd(0, A_DATA, v);
    chk("R9 pwm sets on bottom", v, 8'h01);
    bus_wr(0, A_DATA, 8'h01);
    pwm_mode = 1'b0;
    pulse(0, 1, 0, 0); bus_rd(0, A_DATA, v);
    chk("R9 normal ignores bottom", v, 8'h00);
    pulse(1, 0, 0, 0); bus_rd(0, A_DATA, v);
    chk("R9 normal sets on wrap", v, 8'h01);
    bus_wr(0, A_DATA, 8'h01);
  endtask

  task automatic t_preclear();
    logic [7:0] v;
    set_all();
    bus_space = 1'b0; bus_addr = A_DATA; wr_data = 8'h07; wr_en = 1'b1; rd_en = 1'b1;
    step();
    wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    chk("R10 read returns pre-clear flags", rd_data, 8'h07);
    bus_rd(0, A_DATA, v);
    chk("R10 following read shows cleared", v, 8'h00);
    step();
    chk("R10 rd_data zero without read", rd_data, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_set();
    t_w1c();
    t_ack();
    t_collision();
    t_mask();
    t_views();
    t_pwm();
    t_preclear();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule